// File: doc/BRIEF.md
# Memory-Mapped Serial Console Bridge

This block gives a processor with a byte-wide bus a serial console. The bus reaches it through one chip select and one register-select bit. Behind that window sit four things: a receive queue filled by a byte-level deserialiser, a one-byte transmit holding register that drains into a byte-level serialiser, a status byte, and a write-only byte that drives a hex display.

Received bytes wait in a 256-entry ring buffer. A request-to-send output pauses the host when the buffer is nearly full. A clear-to-send input can gate transmission. At reset the block samples that input. If the input is high at that point, the block treats it as unconnected and ignores it from then on.

A separate detector watches the raw receive line. If the line stays low for longer than one character time, which is a break, the detector raises a reset request for the processor.

Top module: `serial_bridge`

## Requirements
- R1: A status read (`bus_sel`=1) returns bit 0 = clear-to-send and bit 1 = receive byte pending. Bits 7..2 read as zero.
- R2: A data read (`bus_sel`=0) returns the oldest queued byte and removes it. The pending flag clears once the queue is empty. Status reads and data reads of an empty queue have no side effect.
- R3: The queue holds `FIFO_DEPTH` (256) bytes and returns them in arrival order. A byte arriving while the queue is full is dropped.
- R4: A data write loads the transmit holding register. `tx_valid` then stays high with `tx_data` stable until `tx_ready` is seen. Clear-to-send reads 0 while the register is occupied. A data write while it is occupied is dropped.
- R5: A status-address write loads `hex_out` and starts no transmission.
- R6: `rts_n` goes high once the free queue space is `LOW_FREE` (16) or less. It returns low only once free space is `HIGH_FREE` (64) or more. It is low after reset.
- R7: If `cts_n` is low while reset is active, a high `cts_n` later blocks `tx_valid` and clears status bit 0. If `cts_n` is high during reset, `cts_n` is ignored until the next reset.
- R8: `cpu_reset_req` rises after `rx_line` has been low for `CHAR_CLKS`+1 consecutive clocks. It falls on the first clock on which the line is high.
- R9: After reset, `rts_n`=0, `tx_valid`=0, `hex_out`=0, `cpu_reset_req`=0, and the status byte is 0x01 whenever clear-to-send is allowed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_cs | input | 1 | Chip select for the register window |
| bus_sel | input | 1 | Register select: 0 = data, 1 = status/hex |
| bus_rd | input | 1 | Read strobe, one cycle per access |
| bus_wr | input | 1 | Write strobe, one cycle per access |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, valid during the read strobe |
| rx_valid | input | 1 | Deserialiser delivers a byte |
| rx_data | input | 8 | Received byte |
| rx_line | input | 1 | Raw receive line, idle high |
| tx_valid | output | 1 | Byte offered to serialiser |
| tx_data | output | 8 | Byte to send |
| tx_ready | input | 1 | Serialiser accepts the offered byte |
| cts_n | input | 1 | Host clear-to-send, active low |
| rts_n | output | 1 | Request-to-send to host, active low |
| hex_out | output | 8 | Hex display register |
| cpu_reset_req | output | 1 | Reset request raised by a line break |

## Verification
Some properties are checked on every cycle:
- status bits 7..2 are zero;
- a blocked transmit offer holds its data;
- `tx_valid` never rises against a high clear-to-send that is being honoured;
- the queue fill count stays in range;
- `rts_n` changes only across the two thresholds;
- a reset request only follows a low line.

Other behaviour can only be shown by the bench scenarios:
- the arrival-order return of a full queue and the loss of overflow bytes;
- the exact clock on which a break is declared;
- the power-up decision on whether clear-to-send is wired;
- the absence of side effects from status reads.

// File: rtl/serial_bridge_pkg.sv
// Shared definitions for the serial console bridge: status bit positions.
package serial_bridge_pkg;
    localparam int ST_CTS_BIT = 0;  // status: transmitter can accept a byte
    localparam int ST_RXP_BIT = 1;  // status: received byte waiting
    typedef logic [7:0] byte_t;
endpackage

// File: rtl/sb_rx_fifo.sv
// Receive ring buffer with hysteresis flow control toward the host.
// Assumes DEPTH is a power of two. A push into a full buffer is dropped.
// A pop of an empty buffer does nothing.
module sb_rx_fifo #(
    parameter int DEPTH     = 256,
    parameter int LOW_FREE  = 16,
    parameter int HIGH_FREE = 64,
    localparam int AW = $clog2(DEPTH),
    localparam int CW = AW + 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          push,
    input  logic [7:0]    push_data,
    input  logic          pop,
    output logic [7:0]    head,
    output logic [CW-1:0] fill,
    output logic          rts_n
);
    logic [7:0]    mem [DEPTH];
    logic [AW-1:0] wr_ptr, rd_ptr;
    logic          do_wr, do_rd;
    logic [CW-1:0] free_cnt;

    assign do_wr    = push && (fill != CW'(DEPTH));
    assign do_rd    = pop && (fill != '0);
    assign head     = mem[rd_ptr];
    assign free_cnt = CW'(DEPTH) - fill;

    // Store an accepted byte at the write pointer.
    always_ff @(posedge clk) begin
        if (do_wr) mem[wr_ptr] <= push_data;
    end

    // Advance pointers and track the fill level.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            fill   <= '0;
        end else begin
            if (do_wr) wr_ptr <= wr_ptr + 1'b1;
            if (do_rd) rd_ptr <= rd_ptr + 1'b1;
            case ({do_wr, do_rd})
                2'b10:   fill <= fill + 1'b1;
                2'b01:   fill <= fill - 1'b1;
                default: fill <= fill;
            endcase
        end
    end

    // Pause the host near full; release once enough space has opened up.
    always_ff @(posedge clk) begin
        if (!rst_n)                          rts_n <= 1'b0;
        else if (free_cnt <= CW'(LOW_FREE))  rts_n <= 1'b1;
        else if (free_cnt >= CW'(HIGH_FREE)) rts_n <= 1'b0;
    end
endmodule

// File: rtl/sb_tx_hold.sv
// One-byte transmit holding register. The offer is gated by cts_ok.
// Assumes the serialiser accepts a byte on tx_valid && tx_ready.
module sb_tx_hold (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       load,
    input  logic [7:0] load_data,
    input  logic       cts_ok,
    input  logic       tx_ready,
    output logic       tx_valid,
    output logic [7:0] tx_data,
    output logic       idle
);
    logic full;

    assign tx_valid = full && cts_ok;
    assign idle     = !full;

    // Capture a byte when empty; release it on handshake.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            full    <= 1'b0;
            tx_data <= '0;
        end else if (full) begin
            if (cts_ok && tx_ready) full <= 1'b0;
        end else if (load) begin
            full    <= 1'b1;
            tx_data <= load_data;
        end
    end
endmodule

// File: rtl/sb_break_det.sv
// Break detector. Asserts req while the line has been low for more than
// CHAR_CLKS consecutive clocks. Assumes rx_line is already synchronous.
module sb_break_det #(
    parameter int CHAR_CLKS = 160,
    localparam int CNTW = $clog2(CHAR_CLKS + 1)
) (
    input  logic clk,
    input  logic rst_n,
    input  logic rx_line,
    output logic req
);
    logic [CNTW-1:0] low_cnt;

    // Count low clocks, saturating at the character time.
    always_ff @(posedge clk) begin
        if (!rst_n || rx_line)                 low_cnt <= '0;
        else if (low_cnt < CNTW'(CHAR_CLKS))   low_cnt <= low_cnt + 1'b1;
    end

    // Raise the request once the low time exceeds one character.
    always_ff @(posedge clk) begin
        if (!rst_n) req <= 1'b0;
        else        req <= !rx_line && (low_cnt >= CNTW'(CHAR_CLKS));
    end
endmodule

// File: rtl/serial_bridge.sv
// Serial console bridge top. Decodes the two-register bus window. Samples
// CTS during reset to decide whether to honour it. Bus strobes are
// single-cycle; read data is combinational during the strobe.
module serial_bridge
    import serial_bridge_pkg::*;
#(
    parameter int FIFO_DEPTH   = 256,
    parameter int LOW_FREE     = 16,
    parameter int HIGH_FREE    = 64,
    parameter int CLKS_PER_BIT = 16,
    parameter int BITS_PER_CHR = 10,
    localparam int CHAR_CLKS = CLKS_PER_BIT * BITS_PER_CHR,
    localparam int CW        = $clog2(FIFO_DEPTH) + 1
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       bus_cs,
    input  logic       bus_sel,
    input  logic       bus_rd,
    input  logic       bus_wr,
    input  logic [7:0] bus_wdata,
    output logic [7:0] bus_rdata,
    input  logic       rx_valid,
    input  logic [7:0] rx_data,
    input  logic       rx_line,
    output logic       tx_valid,
    output logic [7:0] tx_data,
    input  logic       tx_ready,
    input  logic       cts_n,
    output logic       rts_n,
    output logic [7:0] hex_out,
    output logic       cpu_reset_req
);
    logic          cts_ignore_q;
    logic          cts_ok, tx_idle, rx_pend;
    logic          data_rd, data_wr, stat_wr;
    logic [7:0]    rx_head;
    logic [CW-1:0] rx_fill;
    byte_t         status;

    assign data_rd = bus_cs && bus_rd && !bus_sel;
    assign data_wr = bus_cs && bus_wr && !bus_sel;
    assign stat_wr = bus_cs && bus_wr &&  bus_sel;
    assign cts_ok  = cts_ignore_q || !cts_n;
    assign rx_pend = (rx_fill != '0);

    // Latch during reset whether CTS idles high (unconnected).
    always_ff @(posedge clk) begin
        if (!rst_n) cts_ignore_q <= cts_n;
    end

    // Hex display register written through the status address.
    always_ff @(posedge clk) begin
        if (!rst_n)       hex_out <= '0;
        else if (stat_wr) hex_out <= bus_wdata;
    end

    // Assemble the status byte and the read mux.
    always_comb begin
        status             = '0;
        status[ST_CTS_BIT] = tx_idle && cts_ok;
        status[ST_RXP_BIT] = rx_pend;
        if (bus_cs && bus_rd) bus_rdata = bus_sel ? status : (rx_pend ? rx_head : 8'h00);
        else                  bus_rdata = 8'h00;
    end

    sb_rx_fifo #(.DEPTH(FIFO_DEPTH), .LOW_FREE(LOW_FREE), .HIGH_FREE(HIGH_FREE)) u_rxq (
        .clk(clk), .rst_n(rst_n), .push(rx_valid), .push_data(rx_data),
        .pop(data_rd), .head(rx_head), .fill(rx_fill), .rts_n(rts_n)
    );

    sb_tx_hold u_txh (
        .clk(clk), .rst_n(rst_n), .load(data_wr), .load_data(bus_wdata),
        .cts_ok(cts_ok), .tx_ready(tx_ready), .tx_valid(tx_valid),
        .tx_data(tx_data), .idle(tx_idle)
    );

    sb_break_det #(.CHAR_CLKS(CHAR_CLKS)) u_brk (
        .clk(clk), .rst_n(rst_n), .rx_line(rx_line), .req(cpu_reset_req)
    );
endmodule

// File: rtl/serial_bridge_chk.sv
// Assertion checker for serial_bridge, bound to every instance of the top.
module serial_bridge_chk #(
    parameter int DEPTH     = 256,
    parameter int LOW_FREE  = 16,
    parameter int HIGH_FREE = 64,
    parameter int CW        = 9
) (
    input logic          clk,
    input logic          rst_n,
    input logic          bus_cs,
    input logic          bus_sel,
    input logic          bus_rd,
    input logic [7:0]    bus_rdata,
    input logic          tx_valid,
    input logic          tx_ready,
    input logic [7:0]    tx_data,
    input logic          cts_n,
    input logic          cts_ignore,
    input logic          rx_line,
    input logic          cpu_reset_req,
    input logic          rts_n,
    input logic [CW-1:0] fill
);
    // R1: unused status bits read as zero
    p_status_pad_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_cs && bus_rd && bus_sel) |-> (bus_rdata[7:2] == 6'b0));

    // R3: fill level never exceeds the buffer depth
    p_fill_bound_r3: assert property (@(posedge clk) disable iff (!rst_n)
        int'(fill) <= DEPTH);

    // R4: a blocked offer keeps its data
    p_tx_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_valid && !tx_ready) |=> $stable(tx_data));

    // R6: rts_n rises only at or below the low free mark
    p_rts_rise_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rts_n) |-> ($past(DEPTH - int'(fill)) <= LOW_FREE));

    // R6: rts_n falls only at or above the high free mark
    p_rts_fall_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(rts_n) |-> ($past(DEPTH - int'(fill)) >= HIGH_FREE));

    // R7: when CTS is honoured, no offer while it is high
    p_cts_gate_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_valid && !cts_ignore) |-> !cts_n);

    // R8: a reset request only follows a low receive line
    p_break_low_r8: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_reset_req |-> $past(!rx_line));
endmodule

bind serial_bridge serial_bridge_chk #(
    .DEPTH(FIFO_DEPTH), .LOW_FREE(LOW_FREE), .HIGH_FREE(HIGH_FREE), .CW(CW)
) u_chk (
    .clk(clk), .rst_n(rst_n), .bus_cs(bus_cs), .bus_sel(bus_sel),
    .bus_rd(bus_rd), .bus_rdata(bus_rdata), .tx_valid(tx_valid),
    .tx_ready(tx_ready), .tx_data(tx_data), .cts_n(cts_n),
    .cts_ignore(cts_ignore_q), .rx_line(rx_line),
    .cpu_reset_req(cpu_reset_req), .rts_n(rts_n), .fill(rx_fill)
);

// File: tb/tb_serial_bridge.sv
// Directed bench for serial_bridge: one task per scenario.
module tb_serial_bridge;
    localparam int CHAR = 160;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       bus_cs = 0, bus_sel = 0, bus_rd = 0, bus_wr = 0;
    logic [7:0] bus_wdata = 0;
    logic [7:0] bus_rdata;
    logic       rx_valid = 0;
    logic [7:0] rx_data = 0;
    logic       rx_line = 1;
    logic       tx_valid, tx_ready = 0;
    logic [7:0] tx_data;
    logic       cts_n = 0;
    logic       rts_n;
    logic [7:0] hex_out;
    logic       cpu_reset_req;
    int         checks = 0, failures = 0;
    bit         done = 0;

    always #2 clk = ~clk;

    serial_bridge dut (
        .clk(clk), .rst_n(rst_n), .bus_cs(bus_cs), .bus_sel(bus_sel),
        .bus_rd(bus_rd), .bus_wr(bus_wr), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata), .rx_valid(rx_valid), .rx_data(rx_data),
        .rx_line(rx_line), .tx_valid(tx_valid), .tx_data(tx_data),
        .tx_ready(tx_ready), .cts_n(cts_n), .rts_n(rts_n),
        .hex_out(hex_out), .cpu_reset_req(cpu_reset_req)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic tick(input int n);
        repeat (n) @(posedge clk);
        @(negedge clk); #1;
    endtask

    task automatic do_reset(input logic cts_level);
        @(negedge clk);
        cts_n = cts_level;
        rst_n = 1'b0;
        tick(3);
        rst_n = 1'b1;
        #0;
    endtask

    task automatic bus_write(input logic sel, input logic [7:0] d);
        @(negedge clk);
        bus_cs = 1; bus_wr = 1; bus_sel = sel; bus_wdata = d;
        @(negedge clk);
        bus_cs = 0; bus_wr = 0;
        #1;
    endtask

    task automatic bus_read(input logic sel, output logic [7:0] d);
        @(negedge clk);
        bus_cs = 1; bus_rd = 1; bus_sel = sel;
        #1 d = bus_rdata;
        @(negedge clk);
        bus_cs = 0; bus_rd = 0;
        #1;
    endtask

    task automatic push(input logic [7:0] d);
        @(negedge clk);
        rx_valid = 1; rx_data = d;
        @(negedge clk);
        rx_valid = 0;
    endtask

    task automatic t_reset_state();
        logic [7:0] s;
        do_reset(1'b0);
        tick(1);
        check("R9 rts_n", rts_n, 0);
        check("R9 tx_valid", tx_valid, 0);
        check("R9 hex_out", hex_out, 0);
        check("R9 cpu_reset_req", cpu_reset_req, 0);
        bus_read(1, s);
        check("R9 status", s, 8'h01);
    endtask

    task automatic t_transmit();
        logic [7:0] s;
        bus_write(0, 8'hA5);
        check("R4 tx_valid", tx_valid, 1);
        check("R4 tx_data", tx_data, 8'hA5);
        bus_read(1, s);
        check("R4 status busy", s, 8'h00);
        bus_write(0, 8'h3C);               // dropped: holder occupied
        check("R4 data held", tx_data, 8'hA5);
        @(negedge clk); tx_ready = 1;
        @(negedge clk); tx_ready = 0; #1;
        check("R4 released", tx_valid, 0);
        tick(2);
        check("R4 dropped write not sent", tx_valid, 0);
        bus_read(1, s);
        check("R4 status idle", s, 8'h01);
    endtask

    task automatic t_cts_honoured();
        logic [7:0] s;
        @(negedge clk); cts_n = 1;
        bus_write(0, 8'h11);
        check("R7 gated tx_valid", tx_valid, 0);
        bus_read(1, s);
        check("R7 gated status", s, 8'h00);
        @(negedge clk); cts_n = 0; #1;
        check("R7 ungated tx_valid", tx_valid, 1);
        check("R7 ungated data", tx_data, 8'h11);
        @(negedge clk); tx_ready = 1;
        @(negedge clk); tx_ready = 0;
    endtask

    task automatic t_hex();
        bus_write(1, 8'h5E);
        check("R5 hex_out", hex_out, 8'h5E);
        check("R5 no tx", tx_valid, 0);
    endtask

    task automatic t_rx_basic();
        logic [7:0] s, d;
        push(8'h42); push(8'h43); #1;
        bus_read(1, s);
        check("R1 status pending", s, 8'h03);
        bus_read(1, s);
        check("R2 status read no side effect", s, 8'h03);
        bus_read(0, d);
        check("R2 first byte", d, 8'h42);
        bus_read(0, d);
        check("R2 second byte", d, 8'h43);
        bus_read(1, s);
        check("R2 pending cleared", s, 8'h01);
        bus_read(0, d);
        bus_read(1, s);
        check("R2 empty read harmless", s, 8'h01);
    endtask

    task automatic t_fill_flow();
        logic [7:0] d, s;
        int bad = 0;
        for (int i = 0; i < 239; i++) push(8'(i) ^ 8'h5A);
        tick(2);
        check("R6 free 17 rts low", rts_n, 0);
        push(8'(239) ^ 8'h5A);
        tick(2);
        check("R6 free 16 rts high", rts_n, 1);
        for (int i = 240; i < 256; i++) push(8'(i) ^ 8'h5A);
        push(8'hEE); push(8'hEF);          // dropped: buffer full
        for (int i = 0; i < 47; i++) begin
            bus_read(0, d);
            if (d !== (8'(i) ^ 8'h5A)) bad++;
        end
        tick(2);
        check("R6 free 47 rts still high", rts_n, 1);
        for (int i = 47; i < 48; i++) begin
            bus_read(0, d);
            if (d !== (8'(i) ^ 8'h5A)) bad++;
        end
        tick(2);
        check("R6 free 48 rts still high", rts_n, 1);
        for (int i = 48; i < 64; i++) begin
            bus_read(0, d);
            if (d !== (8'(i) ^ 8'h5A)) bad++;
        end
        tick(2);
        check("R6 free 64 rts low", rts_n, 0);
        for (int i = 64; i < 256; i++) begin
            bus_read(0, d);
            if (d !== (8'(i) ^ 8'h5A)) bad++;
        end
        check("R3 order mismatches", bad, 0);
        bus_read(1, s);
        check("R3 overflow bytes dropped", s, 8'h01);
    endtask

    task automatic t_break();
        @(negedge clk); rx_line = 0;
        repeat (CHAR) @(posedge clk);
        #1;
        check("R8 no request at char time", cpu_reset_req, 0);
        @(posedge clk); #1;
        check("R8 request after char time", cpu_reset_req, 1);
        @(negedge clk); rx_line = 1;
        @(posedge clk); #1;
        check("R8 request clears", cpu_reset_req, 0);
    endtask

    task automatic t_cts_ignored();
        logic [7:0] s;
        do_reset(1'b1);
        tick(1);
        bus_read(1, s);
        check("R7 ignored status", s, 8'h01);
        bus_write(0, 8'h77);
        check("R7 ignored tx_valid", tx_valid, 1);
        check("R7 ignored tx_data", tx_data, 8'h77);
    endtask

    initial begin
        t_reset_state();
        t_transmit();
        t_cts_honoured();
        t_hex();
        t_rx_basic();
        t_fill_flow();
        t_break();
        t_cts_ignored();
        if (!done) begin
            done = 1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            done = 1;
            checks++; failures++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule